// File: doc/BRIEF.md
# Multichannel Sample Serializer with Training Patterns

Top module: `adc_frame_serializer`

This block turns one parallel sample per conversion period on each of several channels into a 12-bit frame. It then shifts that frame out one bit per clock on a dedicated serial line for each channel. A free-running bit counter steps from 0 to 11. The sample bus is captured in the last bit cycle of each frame. A frame-start strobe marks the first bit of every frame, so a receiver can find word boundaries.

A small register file is written one nibble at a time through a 4-bit address and 4-bit data port. It chooses what each frame carries. The choices are the live sample padded with two zero bits, an alternating deskew word, a half-zero/half-one sync word, or a 12-bit word assembled from three custom nibbles. The register file also picks LSB-first or MSB-first shifting and holds one power-down bit per channel. Two output-drive settings are stored and presented on output pins only, with no effect on the data.

Configuration is sampled once per frame, at the load point. The frame on the wire therefore never mixes two settings. In the pattern modes, every active channel shifts the same word in lockstep.

## Requirements
- R1: A synchronous reset clears every register. In the first cycle after reset, frame_start is 1, every serial output is 0, data_drive is 0 and clk_drive_x2 is 0. The frame shifting out right after reset is all zeros.
- R2: frame_start is 1 in the first bit cycle of every frame and 0 in the other 11 cycles, which gives a period of 12 clocks.
- R3: In normal mode (address 0, data bits [1:0] = 00), the frame word is the 10-bit channel sample shifted left by two. The sample is captured in the last bit cycle before the frame. In the default LSB-first order, frame bit 0 goes out first and bit 11 goes out last.
- R4: Writing 1 to address 1, data bit 2, selects MSB-first order. Frame bit 11 then goes out first and bit 0 goes out last.
- R5: Mode 01 sends the deskew word 0x555. Bit 0 is 1 and the bits alternate from there.
- R6: Mode 10 sends the sync word 0xFC0.
- R7: Mode 11 sends the custom word. Addresses 4, 5 and 6 hold its bits [3:0], [7:4] and [11:8].
- R8: Address 2, data bit k, powers down channel k (serial output k) for k = 0..3. Address 3, data bit k, powers down channel k+4. A powered-down channel outputs a constant 0 in every mode.
- R9: Address 0, data bits [3:2], appear on data_drive. Address 1, data bit 0, appears on clk_drive_x2. Both are visible from the cycle after the write and have no effect on serial data. Writes to addresses 7 to 15 change nothing.
- R10: A write made while a frame is shifting leaves that frame unchanged. The write takes effect from a later frame load.
- R11: In modes 01, 10 and 11, all channels that are not powered down output identical bits in the same cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_data | input | 4 | Register write nibble |
| sample_in | input | NCH*SW | Channel samples, channel c at bits [c*SW +: SW] |
| ser_out | output | NCH | Serial data, one bit per channel |
| frame_start | output | 1 | High on the first bit of each frame |
| data_drive | output | 2 | Stored data-drive code |
| clk_drive_x2 | output | 1 | Stored clock-drive doubling flag |

## Verification
The bench builds the block with its defaults, eight channels of 10-bit samples. With these values both power-down registers map onto real channels. The custom pattern fills exactly one 12-bit frame, so every bit position of every mode appears on the wire in both shift orders. Random mixes of mode, order, power-down and custom nibbles are combined with directed cases: writes landing mid-frame, writes to unused addresses, and a reset applied while busy.

// File: rtl/adc_frame_serializer.sv
module adc_frame_serializer #(
  parameter int NCH = 8,
  parameter int SW  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [3:0]      cfg_addr,
  input  logic [3:0]      cfg_data,
  input  logic [NCH*SW-1:0] sample_in,
  output logic [NCH-1:0]  ser_out,
  output logic            frame_start,
  output logic [1:0]      data_drive,
  output logic            clk_drive_x2
);
  localparam int FW = SW + 2;
  localparam int CW = $clog2(FW);

  logic [CW-1:0]  cnt;
  logic           last;
  logic [3:0]     r_mode;
  logic           r_msb;
  logic           r_x2;
  logic [7:0]     r_pd;
  logic [11:0]    r_cust;
  logic [FW-1:0]  deskew, sync_w, pat;
  logic [1:0]     mode_act;
  logic           msb_act;
  logic [NCH-1:0] pd_act;

  function automatic logic [FW-1:0] flip(input logic [FW-1:0] v);
    for (int i = 0; i < FW; i++) flip[i] = v[FW-1-i];
  endfunction

  assign last        = (cnt == CW'(FW-1));
  assign frame_start = (cnt == '0);
  assign data_drive  = r_mode[3:2];
  assign clk_drive_x2 = r_x2;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_mode <= '0; r_msb <= 1'b0; r_x2 <= 1'b0; r_pd <= '0; r_cust <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        4'd0: r_mode <= cfg_data;
        4'd1: begin r_msb <= cfg_data[2]; r_x2 <= cfg_data[0]; end
        4'd2: r_pd[3:0]    <= cfg_data;
        4'd3: r_pd[7:4]    <= cfg_data;
        4'd4: r_cust[3:0]  <= cfg_data;
        4'd5: r_cust[7:4]  <= cfg_data;
        4'd6: r_cust[11:8] <= cfg_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int i = 0; i < FW; i++) begin
      deskew[i] = (i % 2 == 0);
      sync_w[i] = (i >= FW/2);
    end
    case (r_mode[1:0])
      2'b01:   pat = deskew;
      2'b10:   pat = sync_w;
      default: pat = FW'(r_cust);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= '0; msb_act <= 1'b0; pd_act <= '0;
    end else if (last) begin
      mode_act <= r_mode[1:0]; msb_act <= r_msb; pd_act <= r_pd[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic [FW-1:0] word, tx, sh;
    assign word = (r_mode[1:0] == 2'b00) ? {sample_in[g*SW +: SW], 2'b00} : pat;
    assign tx   = r_msb ? flip(word) : word;
    always_ff @(posedge clk) begin
      if (rst)       sh <= '0;
      else if (last) sh <= r_pd[g] ? '0 : tx;
      else           sh <= sh >> 1;
    end
    assign ser_out[g] = sh[0];
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ser_out == '0 && data_drive == 2'b00 && !clk_drive_x2 && frame_start)); // R1
  AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    last |=> frame_start); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start); // R2
  AST_SYNC_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (mode_act == 2'b10 && !pd_act[0]) |-> (ser_out[0] == ((cnt >= CW'(FW/2)) ^ msb_act))); // R6
  AST_PD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (ser_out & pd_act) == '0); // R8
  AST_PATTERN_LOCKSTEP: assert property (@(posedge clk) disable iff (rst)
    (mode_act != 2'b00) |-> (((ser_out & ~pd_act) == '0) || ((ser_out | pd_act) == '1))); // R11
endmodule

// File: tb/adc_frame_serializer_test.sv
module adc_frame_serializer_test;
  localparam int NCH = 8;
  localparam int SW  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0, cfg_data = '0;
  logic [NCH*SW-1:0] sample_in = '0;
  logic [NCH-1:0] ser_out;
  logic frame_start;
  logic [1:0] data_drive;
  logic clk_drive_x2;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  logic [3:0]  m_r0 = '0;
  logic        m_msb = 1'b0, m_x2 = 1'b0;
  logic [7:0]  m_pd = '0;
  logic [11:0] m_cust = '0;
  logic [11:0] rx [NCH];

  adc_frame_serializer #(.NCH(NCH), .SW(SW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .sample_in(sample_in), .ser_out(ser_out), .frame_start(frame_start),
    .data_drive(data_drive), .clk_drive_x2(clk_drive_x2));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_word(input logic [1:0] mode, input logic [9:0] s, input logic [11:0] c);
    case (mode)
      2'b00:   return {s, 2'b00};
      2'b01:   return 12'h555;
      2'b10:   return 12'hFC0;
      default: return c;
    endcase
  endfunction

  function automatic logic [11:0] wire_seq(input logic [11:0] w, input logic msb);
    logic [11:0] r;
    for (int i = 0; i < 12; i++) r[i] = msb ? w[11-i] : w[i];
    return r;
  endfunction

  task automatic apply_model(input logic [3:0] a, input logic [3:0] d);
    case (a)
      4'd0: m_r0 = d;
      4'd1: begin m_msb = d[2]; m_x2 = d[0]; end
      4'd2: m_pd[3:0] = d;
      4'd3: m_pd[7:4] = d;
      4'd4: m_cust[3:0] = d;
      4'd5: m_cust[7:4] = d;
      4'd6: m_cust[11:8] = d;
      default: ;
    endcase
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    apply_model(a, d);
    chk(data_drive == m_r0[3:2] && clk_drive_x2 == m_x2, "R9 drive outputs",
        {29'd0, data_drive, clk_drive_x2}, {29'd0, m_r0[3:2], m_x2});
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_r0 = '0; m_msb = 1'b0; m_x2 = 1'b0; m_pd = '0; m_cust = '0;
    chk(frame_start && ser_out == '0 && data_drive == 2'b00 && !clk_drive_x2, "R1 reset state",
        {20'd0, frame_start, ser_out, data_drive, clk_drive_x2}, {20'd0, 1'b1, 8'd0, 2'd0, 1'b0});
  endtask

  task automatic run(input int mid_i, input logic [3:0] ma, input logic [3:0] md);
    logic [1:0]  s_mode;
    logic        s_msb;
    logic [7:0]  s_pd;
    logic [11:0] s_cust, e, ref_bits;
    logic [9:0]  smp [NCH];
    bit fs_ok;
    bit have_ref;
    string tag;
    for (int c = 0; c < NCH; c++) begin
      smp[c] = 10'($urandom);
      sample_in[c*SW +: SW] = smp[c];
    end
    s_mode = m_r0[1:0]; s_msb = m_msb; s_pd = m_pd; s_cust = m_cust;
    do @(negedge clk); while (!frame_start);
    fs_ok = 1'b1;
    for (int i = 0; i < 12; i++) begin
      for (int c = 0; c < NCH; c++) rx[c][i] = ser_out[c];
      if (frame_start != (i == 0)) fs_ok = 1'b0;
      if (i == mid_i) begin cfg_we = 1'b1; cfg_addr = ma; cfg_data = md; end
      @(negedge clk);
      if (i == mid_i) begin cfg_we = 1'b0; apply_model(ma, md); end
    end
    chk(fs_ok && frame_start, "R2 frame strobe", {31'd0, fs_ok}, 32'd1);
    have_ref = 1'b0; ref_bits = '0;
    for (int c = 0; c < NCH; c++) begin
      if (s_pd[c]) begin
        e = '0; tag = "R8 power-down";
      end else begin
        e = wire_seq(exp_word(s_mode, smp[c], s_cust), s_msb);
        case (s_mode)
          2'b00:   tag = s_msb ? "R4 msb normal" : "R3 lsb normal";
          2'b01:   tag = "R5 deskew";
          2'b10:   tag = "R6 sync";
          default: tag = "R7 custom";
        endcase
        if (mid_i >= 0) tag = {tag, " R10 in-flight"};
        if (s_mode != 2'b00) begin
          if (have_ref)
            chk(rx[c] == ref_bits, "R11 lockstep", {20'd0, rx[c]}, {20'd0, ref_bits});
          have_ref = 1'b1; ref_bits = rx[c];
        end
      end
      chk(rx[c] == e, tag, {20'd0, rx[c]}, {20'd0, e});
    end
  endtask

  initial begin
    #1500000;
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    for (int i = 0; i < 12; i++) begin
      chk(ser_out == '0, "R1 zero frame after reset", {24'd0, ser_out}, 32'd0);
      @(negedge clk);
    end
    run(-1, 0, 0);
    wr(4'd1, 4'b0100); run(-1, 0, 0);
    wr(4'd0, 4'b0001); run(-1, 0, 0);
    wr(4'd1, 4'b0000); run(-1, 0, 0);
    wr(4'd0, 4'b0010); run(-1, 0, 0);
    wr(4'd1, 4'b0100); run(-1, 0, 0);
    wr(4'd4, 4'hA); wr(4'd5, 4'h3); wr(4'd6, 4'hC); wr(4'd0, 4'b0011); run(-1, 0, 0);
    wr(4'd1, 4'b0000); run(-1, 0, 0);
    wr(4'd2, 4'b1010); wr(4'd3, 4'b0101); wr(4'd0, 4'b0000); run(-1, 0, 0);
    wr(4'd0, 4'b0001); run(-1, 0, 0);
    wr(4'd0, 4'b1100); wr(4'd1, 4'b0001); wr(4'd7, 4'hF); wr(4'd15, 4'h3); run(-1, 0, 0);
    wr(4'd2, 4'b0000); wr(4'd3, 4'b0000); run(5, 4'd0, 4'b0010);
    run(-1, 0, 0);
    run(0, 4'd1, 4'b0100);
    run(10, 4'd2, 4'b1111);
    run(-1, 0, 0);
    for (int n = 0; n < 200; n++) begin
      int nw;
      nw = int'($urandom % 4);
      for (int k = 0; k < nw; k++) wr(4'($urandom % 8), 4'($urandom));
      if ($urandom % 4 == 0) run(int'($urandom % 12), 4'($urandom % 8), 4'($urandom));
      else run(-1, 0, 0);
    end
    wr(4'd0, 4'b1111); wr(4'd2, 4'hF);
    @(negedge clk); @(negedge clk); @(negedge clk);
    do_reset();
    run(-1, 0, 0);
    run(-1, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule